// File: doc/BRIEF.md
# Trap and Interrupt Context Unit

This unit handles the control-transfer opcodes that touch machine context: subroutine call and return, system call, software interrupt and interrupt return. It keeps three context slots (saved instruction pointer, saved stack pointer and saved flags). It drives next-value buses with load strobes for the instruction pointer, stack pointer and flag register. It fetches handler addresses from an external vector table through a synchronous read port. The table returns data one cycle after the read strobe.

Entering a handler through a system call or software interrupt saves all three registers at once. In the same cycle the unit clears the user-mode and interrupt-enable flag bits, which moves the machine into supervisor mode with interrupts masked. In the next cycle the instruction pointer is loaded from the table, while a busy output stalls the pipeline. The software interrupt and the interrupt return are privileged. In user mode they raise a fault strobe and change nothing.

Top module: `trap_ctx_unit`

## Requirements
- R1: After reset, busy, priv_fault, vec_rd, ip_load, sp_load and flags_load are all 0.
- R2: A valid call (opcode 160) stores cur_ip in the saved-IP slot and asserts no load strobe.
- R3: A valid return (opcode 161) asserts ip_load in the same cycle with nxt_ip equal to the saved-IP slot; sp_load and flags_load stay 0.
- R4: A valid system call (opcode 162) stores cur_ip, cur_sp and cur_flags in the three slots, asserts vec_rd with vec_addr = 6, and asserts flags_load with nxt_flags equal to cur_flags with bits 16 and 17 cleared; sp_load and ip_load stay 0 in that cycle.
- R5: A valid software interrupt (opcode 192) in supervisor mode (cur_flags bit 16 = 0) behaves as R4 but with vec_addr equal to imm bits 7:0.
- R6: In the cycle after a system call or software interrupt is accepted, busy = 1, ip_load = 1 and nxt_ip equals vec_data. busy is 0 again one cycle later.
- R7: A valid interrupt return (opcode 193) in supervisor mode asserts ip_load, sp_load and flags_load in the same cycle, with nxt_ip, nxt_sp and nxt_flags taken from the three slots.
- R8: Opcode 192 or 193 with cur_flags bit 16 = 1 asserts priv_fault for that cycle only, asserts no load strobe and no vec_rd, and leaves all three slots unchanged.
- R9: Call, return and system call are accepted in user mode (cur_flags bit 16 = 1).
- R10: With op_valid low, with any other opcode, or while busy is high, the unit asserts no load strobe, no vec_rd and no priv_fault, apart from the ip_load of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Opcode present this cycle |
| opcode | input | 8 | Opcode |
| imm | input | 32 | Immediate; low 8 bits index the vector table |
| cur_ip | input | 32 | Current instruction pointer |
| cur_sp | input | 32 | Current stack pointer |
| cur_flags | input | 32 | Current flags (bit 16 user mode, bit 17 interrupt enable) |
| vec_rd | output | 1 | Vector table read strobe |
| vec_addr | output | 8 | Vector table index |
| vec_data | input | 32 | Vector table read data, valid the cycle after vec_rd |
| nxt_ip | output | 32 | Next instruction pointer |
| ip_load | output | 1 | Load nxt_ip |
| nxt_sp | output | 32 | Next stack pointer |
| sp_load | output | 1 | Load nxt_sp |
| nxt_flags | output | 32 | Next flags |
| flags_load | output | 1 | Load nxt_flags |
| busy | output | 1 | Trap second cycle in progress; stall |
| priv_fault | output | 1 | Privileged opcode issued in user mode |

## Verification
The assertions assume that the vector table answers exactly one cycle after vec_rd. They also assume that cur_flags is a stable register value during the cycle an opcode is presented. The bench models the table as a registered function of the index, so every handler address is known in advance. It changes inputs only on the falling edge. Opcodes offered while busy is high are assumed to be ignored rather than replayed. The bench offers a return during that cycle to confirm that the vector data still wins.

// File: rtl/trap_ctx_unit.sv
`timescale 1ns/1ps
module trap_ctx_unit #(
  parameter int XLEN      = 32,
  parameter int FLAG_W    = 32,
  parameter int OP_W      = 8,
  parameter int VEC_AW    = 8,
  parameter int SCALL_VEC = 6,
  parameter int USER_BIT  = 16,
  parameter int IE_BIT    = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [OP_W-1:0]   opcode,
  input  logic [XLEN-1:0]   imm,
  input  logic [XLEN-1:0]   cur_ip,
  input  logic [XLEN-1:0]   cur_sp,
  input  logic [FLAG_W-1:0] cur_flags,
  output logic              vec_rd,
  output logic [VEC_AW-1:0] vec_addr,
  input  logic [XLEN-1:0]   vec_data,
  output logic [XLEN-1:0]   nxt_ip,
  output logic              ip_load,
  output logic [XLEN-1:0]   nxt_sp,
  output logic              sp_load,
  output logic [FLAG_W-1:0] nxt_flags,
  output logic              flags_load,
  output logic              busy,
  output logic              priv_fault
);
  localparam logic [OP_W-1:0]   OP_CALL  = OP_W'(160);
  localparam logic [OP_W-1:0]   OP_RET   = OP_W'(161);
  localparam logic [OP_W-1:0]   OP_SCALL = OP_W'(162);
  localparam logic [OP_W-1:0]   OP_INT   = OP_W'(192);
  localparam logic [OP_W-1:0]   OP_IRET  = OP_W'(193);
  localparam logic [FLAG_W-1:0] CLR_MASK = (FLAG_W'(1) << USER_BIT) | (FLAG_W'(1) << IE_BIT);

  logic [XLEN-1:0]   ctx_ip, ctx_sp;
  logic [FLAG_W-1:0] ctx_flags;
  logic              wait_q;

  logic unused_imm;
  assign unused_imm = ^imm[XLEN-1:VEC_AW];

  wire go       = op_valid && !wait_q;
  wire user     = cur_flags[USER_BIT];
  wire is_call  = go && opcode == OP_CALL;
  wire is_ret   = go && opcode == OP_RET;
  wire is_scall = go && opcode == OP_SCALL;
  wire is_int   = go && opcode == OP_INT;
  wire is_iret  = go && opcode == OP_IRET;
  wire trap     = is_scall || (is_int && !user);
  wire iret_ok  = is_iret && !user;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctx_ip    <= '0;
      ctx_sp    <= '0;
      ctx_flags <= '0;
      wait_q    <= 1'b0;
    end else begin
      wait_q <= trap;
      if (trap) begin
        ctx_ip    <= cur_ip;
        ctx_sp    <= cur_sp;
        ctx_flags <= cur_flags;
      end else if (is_call) begin
        ctx_ip <= cur_ip;
      end
    end
  end

  assign priv_fault = (is_int || is_iret) && user;
  assign vec_rd     = trap;
  assign vec_addr   = is_scall ? VEC_AW'(SCALL_VEC) : imm[VEC_AW-1:0];
  assign ip_load    = wait_q || is_ret || iret_ok;
  assign nxt_ip     = wait_q ? vec_data : ctx_ip;
  assign sp_load    = iret_ok;
  assign nxt_sp     = ctx_sp;
  assign flags_load = trap || iret_ok;
  assign nxt_flags  = trap ? (cur_flags & ~CLR_MASK) : ctx_flags;
  assign busy       = wait_q;

  a_r8_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    priv_fault |-> !(ip_load || sp_load || flags_load || vec_rd));

  a_r8_ctx_kept: assert property (@(posedge clk) disable iff (!rst_n)
    priv_fault |=> (ctx_ip == $past(ctx_ip)) && (ctx_sp == $past(ctx_sp)) && (ctx_flags == $past(ctx_flags)));

  a_r6_vector_next: assert property (@(posedge clk) disable iff (!rst_n)
    vec_rd |=> busy && ip_load);

  a_r6_single_wait: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  a_r4_mode_switch: assert property (@(posedge clk) disable iff (!rst_n)
    vec_rd |-> flags_load && !nxt_flags[USER_BIT] && !nxt_flags[IE_BIT] && !sp_load);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && !busy) |-> !(ip_load || sp_load || flags_load || vec_rd || priv_fault));
endmodule

// File: tb/trap_ctx_unit_test.sv
`timescale 1ns/1ps
module trap_ctx_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [7:0] opcode = '0;
  logic [31:0] imm = '0, cur_ip = '0, cur_sp = '0, cur_flags = '0;
  logic vec_rd;
  logic [7:0] vec_addr;
  logic [31:0] vec_data = '0;
  logic [31:0] nxt_ip, nxt_sp, nxt_flags;
  logic ip_load, sp_load, flags_load, busy, priv_fault;
  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  trap_ctx_unit uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode), .imm(imm),
    .cur_ip(cur_ip), .cur_sp(cur_sp), .cur_flags(cur_flags),
    .vec_rd(vec_rd), .vec_addr(vec_addr), .vec_data(vec_data),
    .nxt_ip(nxt_ip), .ip_load(ip_load), .nxt_sp(nxt_sp), .sp_load(sp_load),
    .nxt_flags(nxt_flags), .flags_load(flags_load), .busy(busy), .priv_fault(priv_fault));

  function automatic logic [31:0] vec_of(input logic [7:0] a);
    return 32'h8000_0000 | (32'(a) << 2);
  endfunction

  always @(posedge clk) if (vec_rd) vec_data <= vec_of(vec_addr);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    check(act == exp, req, act, exp);
  endtask

  task automatic strobes(input string req, input logic [4:0] exp);
    chk(req, {27'd0, ip_load, sp_load, flags_load, vec_rd, priv_fault}, {27'd0, exp});
  endtask

  task automatic next_cycle();
    @(negedge clk);
    op_valid = 1'b0;
    #1;
  endtask

  task automatic issue(input logic [7:0] op, input logic [31:0] fl);
    @(negedge clk);
    op_valid = 1'b1; opcode = op; cur_flags = fl;
    #1;
  endtask

  task automatic t_reset();
    strobes("R1 strobes", 5'b00000);
    chk("R1 busy", 32'(busy), 0);
  endtask

  task automatic t_call_ret();
    cur_ip = 32'h0000_0100;
    issue(8'd160, 32'h0);
    strobes("R2 call no loads", 5'b00000);
    issue(8'd161, 32'h0);
    strobes("R3 ret strobes", 5'b10000);
    chk("R3 ret ip", nxt_ip, 32'h100);
    cur_ip = 32'h0000_0200;
    issue(8'd160, 32'h0001_0000);
    strobes("R9 user call", 5'b00000);
    issue(8'd161, 32'h0001_0000);
    strobes("R9 user ret strobes", 5'b10000);
    chk("R9 user ret ip", nxt_ip, 32'h200);
    next_cycle();
  endtask

  task automatic t_scall();
    cur_ip = 32'h0000_0400; cur_sp = 32'h0000_8000; imm = 32'h0000_0077;
    issue(8'd162, 32'h0003_00F5);
    strobes("R4 R9 scall strobes", 5'b00110);
    chk("R4 scall addr", 32'(vec_addr), 6);
    chk("R4 scall flags", nxt_flags, 32'h0000_00F5);
    @(negedge clk);
    opcode = 8'd161; #1;
    chk("R6 busy", 32'(busy), 1);
    strobes("R6 R10 wait strobes", 5'b10000);
    chk("R6 vector ip", nxt_ip, vec_of(8'd6));
    next_cycle();
    chk("R6 busy drops", 32'(busy), 0);
    issue(8'd193, 32'h0);
    strobes("R7 iret strobes", 5'b11100);
    chk("R7 iret ip", nxt_ip, 32'h400);
    chk("R7 iret sp", nxt_sp, 32'h8000);
    chk("R7 iret flags", nxt_flags, 32'h0003_00F5);
    next_cycle();
  endtask

  task automatic t_int();
    cur_ip = 32'h0000_0500; cur_sp = 32'h0000_9000; imm = 32'hABCD_0133;
    issue(8'd192, 32'h0002_0001);
    strobes("R5 int strobes", 5'b00110);
    chk("R5 int addr", 32'(vec_addr), 32'h33);
    chk("R5 int flags", nxt_flags, 32'h0000_0001);
    next_cycle();
    strobes("R6 int wait", 5'b10000);
    chk("R6 int vector ip", nxt_ip, vec_of(8'h33));
    next_cycle();
    chk("R6 int busy drops", 32'(busy), 0);
  endtask

  task automatic t_fault();
    cur_ip = 32'h0000_0BAD; cur_sp = 32'h0000_0BAD; imm = 32'h0000_0010;
    issue(8'd192, 32'h0001_0000);
    strobes("R8 user int", 5'b00001);
    next_cycle();
    strobes("R8 fault one cycle", 5'b00000);
    issue(8'd193, 32'h0001_0000);
    strobes("R8 user iret", 5'b00001);
    issue(8'd193, 32'h0);
    chk("R8 slot ip kept", nxt_ip, 32'h500);
    chk("R8 slot sp kept", nxt_sp, 32'h9000);
    chk("R8 slot flags kept", nxt_flags, 32'h0002_0001);
    next_cycle();
  endtask

  task automatic t_other();
    issue(8'd1, 32'h0);
    strobes("R10 opcode 1", 5'b00000);
    issue(8'd128, 32'h0);
    strobes("R10 opcode 128", 5'b00000);
    issue(8'd0, 32'h0001_0000);
    strobes("R10 opcode 0", 5'b00000);
    @(negedge clk);
    op_valid = 1'b0; opcode = 8'd193; cur_flags = 32'h0; #1;
    strobes("R10 invalid iret", 5'b00000);
    opcode = 8'd162; #1;
    strobes("R10 invalid scall", 5'b00000);
    next_cycle();
    chk("R10 no busy", 32'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_call_ret();
    t_scall();
    t_int();
    t_fault();
    t_other();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule